// File: doc/BRIEF.md
# Domain and Access-Permission Checker

This block sits after a finished translation-table walk and decides whether a memory access may go ahead. It takes the attributes the walk produced: a 3-bit access-permission code, the execute-never and privileged-execute-never bits and a 4-bit domain number. It also takes the kind of access (read, write or instruction fetch), whether the access comes from user mode, and a flag that selects the access-flag permission mode. From these it produces read, write and execute permission flags and a 2-bit fault code.

A 32-bit domain control register holds a 2-bit setting for each of the sixteen domains and is loaded through a simple write port. Each domain is either blocked, a client that is checked against the descriptor attributes, or a manager that bypasses every check. The verdict is registered and appears one clock after a valid request.

Top module: `perm_check_top`

## Requirements
- R1: A request presented with `req_valid` high produces `rsp_valid` high on the next cycle. `rsp_valid` is low in any cycle that follows a cycle without a request. The response fields keep their values while no request is taken.
- R2: The domain control register clears to zero on reset, so every domain gives a domain fault. A write through `dacr_we` takes effect for requests in later cycles. A request in the same cycle as the write still uses the old contents.
- R3: The setting of domain d is held in register bits [2d+1:2d]. Setting 0 (blocked) or 2 (reserved) gives fault code 1 (domain fault).
- R4: Setting 3 (manager) gives read, write and execute with fault code 0, whatever the AP code, execute-never bits, mode and access type are.
- R5: For setting 1 (client), a set `req_pxn` acts as execute-never when `req_user` is 0. It has no effect when `req_user` is 1.
- R6: For a client, an instruction fetch (`req_acc` = 2 or 3) with execute-never in effect gives fault code 3 (permission). This check is made before the access-flag check.
- R7: For a client with `req_afe` = 1, AP[0] = 0 gives fault code 2 (access flag).
- R8: With `req_afe` = 1, AP[2:1] decodes as follows. 0 gives privileged read/write. 1 gives read/write for everyone. 2 gives privileged read-only. 3 gives read-only for everyone. In each case a user access not listed gets no access.
- R9: With `req_afe` = 0, AP[2:0] decodes as follows. 1 gives privileged read/write. 2 gives privileged read/write and user read. 3 gives read/write for everyone. 5 gives privileged read. 6 and 7 give read for everyone. 0 and 4 give no access.
- R10: For a client, execute is granted only when read or write is granted and execute-never is not in effect.
- R11: Access type 0 is read, 1 is write, and 2 or 3 is fetch. A client access whose own permission is not granted gives fault code 3.
- R12: Whenever the fault code is non-zero, the read, write and execute flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dacr_we | input | 1 | Write enable for the domain control register |
| dacr_wdata | input | 32 | New domain control register value |
| req_valid | input | 1 | Request strobe |
| req_ap | input | 3 | Access-permission code from the descriptor |
| req_xn | input | 1 | Execute-never |
| req_pxn | input | 1 | Privileged execute-never |
| req_domain | input | 4 | Domain number |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2/3 fetch |
| req_user | input | 1 | Access is from user mode |
| req_afe | input | 1 | Access-flag mode enable |
| rsp_valid | output | 1 | Verdict valid |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_fault | output | 2 | 0 none, 1 domain, 2 access flag, 3 permission |

## Verification
The only state is the domain control register and the response register. A corrupted domain setting therefore shows on the first request that names that domain, one cycle later: a fault code of 1 appears where a grant was due, or a manager-style full grant appears where a client check was due. The bench writes a different setting into each domain position and then queries every domain, so a wrong bit position in the register is caught as soon as the sweep reaches it. A response register that loads when no request is present shows up at the ports as a changed verdict in an idle cycle.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_DOMAIN  = 2'd1,
    FLT_ACCFLAG = 2'd2,
    FLT_PERM    = 2'd3
  } fault_e;

  localparam logic [1:0] DOM_BLOCKED = 2'd0;
  localparam logic [1:0] DOM_CLIENT  = 2'd1;
  localparam logic [1:0] DOM_RSVD    = 2'd2;
  localparam logic [1:0] DOM_MANAGER = 2'd3;

  typedef struct packed {
    logic   rd;
    logic   wr;
    logic   ex;
    fault_e fault;
  } verdict_t;

endpackage

// File: rtl/perm_dom_reg.sv
module perm_dom_reg #(
  parameter int NUM_DOM = 16,
  localparam int SEL_W  = $clog2(NUM_DOM),
  localparam int REG_W  = 2 * NUM_DOM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic [SEL_W-1:0] sel,
  output logic [REG_W-1:0] dacr_q,
  output logic [1:0]       dom_val
);

  logic [REG_W-1:0] dacr_d;
  logic [1:0]       field [NUM_DOM];

  always_comb begin
    dacr_d = dacr_q;
    if (we) begin
      dacr_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dacr_q <= '0;
    end else if (we) begin
      dacr_q <= dacr_d;
    end
  end

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
    assign field[g] = dacr_q[2*g +: 2];
  end

  assign dom_val = field[sel];

endmodule

// File: rtl/perm_ap_decode.sv
module perm_ap_decode (
  input  logic [2:0] ap,
  input  logic       user,
  input  logic       afe,
  output logic       rd,
  output logic       wr,
  output logic       af_miss
);

  logic priv;
  assign priv = !user;

  always_comb begin
    rd      = 1'b0;
    wr      = 1'b0;
    af_miss = 1'b0;
    if (afe) begin
      af_miss = !ap[0];
      unique case (ap[2:1])
        2'd0: begin rd = priv; wr = priv; end
        2'd1: begin rd = 1'b1; wr = 1'b1; end
        2'd2: begin rd = priv; end
        2'd3: begin rd = 1'b1; end
        default: ;
      endcase
    end else begin
      unique case (ap)
        3'd1:       begin rd = priv; wr = priv; end
        3'd2:       begin rd = 1'b1; wr = priv; end
        3'd3:       begin rd = 1'b1; wr = 1'b1; end
        3'd5:       begin rd = priv; end
        3'd6, 3'd7: begin rd = 1'b1; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/perm_eval.sv
module perm_eval
  import perm_pkg::*;
(
  input  logic [1:0] dom_val,
  input  logic       rd_raw,
  input  logic       wr_raw,
  input  logic       af_miss,
  input  logic       xn,
  input  logic       pxn,
  input  logic       user,
  input  logic [1:0] acc,
  output verdict_t   verdict
);

  logic xn_eff, fetch, ex_raw, granted;

  assign xn_eff  = xn | (pxn & !user);
  assign fetch   = acc[1];
  assign ex_raw  = (rd_raw | wr_raw) & !xn_eff;
  assign granted = fetch ? ex_raw : (acc[0] ? wr_raw : rd_raw);

  always_comb begin
    verdict = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, fault: FLT_NONE};
    unique case (dom_val)
      DOM_MANAGER: begin
        verdict.rd = 1'b1;
        verdict.wr = 1'b1;
        verdict.ex = 1'b1;
      end
      DOM_CLIENT: begin
        if (xn_eff && fetch) begin
          verdict.fault = FLT_PERM;
        end else if (af_miss) begin
          verdict.fault = FLT_ACCFLAG;
        end else if (!granted) begin
          verdict.fault = FLT_PERM;
        end else begin
          verdict.rd = rd_raw;
          verdict.wr = wr_raw;
          verdict.ex = ex_raw;
        end
      end
      default: verdict.fault = FLT_DOMAIN;
    endcase
  end

endmodule

// File: rtl/perm_check_top.sv
module perm_check_top
  import perm_pkg::*;
#(
  parameter int NUM_DOM = 16,
  localparam int SEL_W  = $clog2(NUM_DOM),
  localparam int REG_W  = 2 * NUM_DOM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dacr_we,
  input  logic [REG_W-1:0] dacr_wdata,
  input  logic             req_valid,
  input  logic [2:0]       req_ap,
  input  logic             req_xn,
  input  logic             req_pxn,
  input  logic [SEL_W-1:0] req_domain,
  input  logic [1:0]       req_acc,
  input  logic             req_user,
  input  logic             req_afe,
  output logic             rsp_valid,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             rsp_ex,
  output logic [1:0]       rsp_fault
);

  logic [1:0]       rst_pipe;
  logic             rst_n_i;
  logic [REG_W-1:0] dacr_q;
  logic [1:0]       dom_val;
  logic             rd_raw, wr_raw, af_miss;
  verdict_t         verdict_c, verdict_d, verdict_q;
  logic             valid_d, valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_i = rst_pipe[1];

  perm_dom_reg #(.NUM_DOM(NUM_DOM)) dom_reg_i (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .we      (dacr_we),
    .wdata   (dacr_wdata),
    .sel     (req_domain),
    .dacr_q  (dacr_q),
    .dom_val (dom_val)
  );

  perm_ap_decode ap_dec_i (
    .ap      (req_ap),
    .user    (req_user),
    .afe     (req_afe),
    .rd      (rd_raw),
    .wr      (wr_raw),
    .af_miss (af_miss)
  );

  perm_eval eval_i (
    .dom_val (dom_val),
    .rd_raw  (rd_raw),
    .wr_raw  (wr_raw),
    .af_miss (af_miss),
    .xn      (req_xn),
    .pxn     (req_pxn),
    .user    (req_user),
    .acc     (req_acc),
    .verdict (verdict_c)
  );

  always_comb begin
    valid_d   = req_valid;
    verdict_d = verdict_q;
    if (req_valid) begin
      verdict_d = verdict_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      verdict_q <= '{rd: 1'b0, wr: 1'b0, ex: 1'b0, fault: FLT_NONE};
    end else if (req_valid) begin
      verdict_q <= verdict_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_rd    = verdict_q.rd;
  assign rsp_wr    = verdict_q.wr;
  assign rsp_ex    = verdict_q.ex;
  assign rsp_fault = verdict_q.fault;

endmodule

// File: rtl/perm_check_sva.sv
module perm_check_sva #(
  parameter int NUM_DOM = 16,
  localparam int SEL_W  = $clog2(NUM_DOM),
  localparam int REG_W  = 2 * NUM_DOM
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] dacr_q,
  input logic             req_valid,
  input logic [2:0]       req_ap,
  input logic             req_xn,
  input logic             req_pxn,
  input logic [SEL_W-1:0] req_domain,
  input logic [1:0]       req_acc,
  input logic             req_user,
  input logic             req_afe,
  input logic             rsp_valid,
  input logic             rsp_rd,
  input logic             rsp_wr,
  input logic             rsp_ex,
  input logic [1:0]       rsp_fault
);

  logic [REG_W-1:0] shifted;
  logic [1:0]       cur_dom;
  assign shifted = dacr_q >> {req_domain, 1'b0};
  assign cur_dom = shifted[1:0];

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable({rsp_rd, rsp_wr, rsp_ex, rsp_fault})); // R1
  AST_DOMAIN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cur_dom[0]) |=> (rsp_fault == 2'd1)); // R3
  AST_MANAGER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_dom == 2'd3) |=> (rsp_rd && rsp_wr && rsp_ex && rsp_fault == 2'd0)); // R4
  AST_XN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_dom == 2'd1 && req_xn && req_acc[1]) |=> (rsp_fault == 2'd3)); // R6
  AST_AF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_dom == 2'd1 && req_afe && !req_ap[0] &&
     !(req_acc[1] && (req_xn || (req_pxn && !req_user)))) |=> (rsp_fault == 2'd2)); // R7
  AST_EXEC_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ex) |-> (rsp_rd || rsp_wr)); // R10
  AST_FAULT_NO_PERMS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (!rsp_rd && !rsp_wr && !rsp_ex)); // R12

endmodule

bind perm_check_top perm_check_sva #(.NUM_DOM(NUM_DOM)) sva_i (
  .clk        (clk),
  .rst_n      (rst_n_i),
  .dacr_q     (dacr_q),
  .req_valid  (req_valid),
  .req_ap     (req_ap),
  .req_xn     (req_xn),
  .req_pxn    (req_pxn),
  .req_domain (req_domain),
  .req_acc    (req_acc),
  .req_user   (req_user),
  .req_afe    (req_afe),
  .rsp_valid  (rsp_valid),
  .rsp_rd     (rsp_rd),
  .rsp_wr     (rsp_wr),
  .rsp_ex     (rsp_ex),
  .rsp_fault  (rsp_fault)
);

// File: tb/perm_check_top_tb_top.sv
`timescale 1ns/1ps
module perm_check_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dacr_we;
  logic [31:0] dacr_wdata;
  logic        req_valid;
  logic [2:0]  req_ap;
  logic        req_xn, req_pxn;
  logic [3:0]  req_domain;
  logic [1:0]  req_acc;
  logic        req_user, req_afe;
  logic        rsp_valid, rsp_rd, rsp_wr, rsp_ex;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow;

  always #2 clk = ~clk;

  perm_check_top dut_i (
    .clk(clk), .rst_n(rst_n), .dacr_we(dacr_we), .dacr_wdata(dacr_wdata),
    .req_valid(req_valid), .req_ap(req_ap), .req_xn(req_xn), .req_pxn(req_pxn),
    .req_domain(req_domain), .req_acc(req_acc), .req_user(req_user), .req_afe(req_afe),
    .rsp_valid(rsp_valid), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
    .rsp_fault(rsp_fault)
  );

  // Expected {rd, wr, ex, fault[1:0]} from the requirements.
  function automatic logic [4:0] model(input int dv, input int ap, input int xn,
                                       input int pxn, input int acc, input int user,
                                       input int afe);
    int rd, wr, ex, xe, need;
    if (dv == 0 || dv == 2) return 5'b000_01;            // R3
    if (dv == 3) return 5'b111_00;                       // R4
    xe = (xn != 0 || (pxn != 0 && user == 0)) ? 1 : 0;  // R5
    if (xe == 1 && acc >= 2) return 5'b000_11;           // R6
    if (afe != 0 && (ap % 2) == 0) return 5'b000_10;     // R7
    rd = 0; wr = 0;
    if (afe != 0) begin                                  // R8
      case (ap / 2)
        0: begin rd = 1 - user; wr = 1 - user; end
        1: begin rd = 1; wr = 1; end
        2: rd = 1 - user;
        default: rd = 1;
      endcase
    end else begin                                       // R9
      case (ap)
        1: begin rd = 1 - user; wr = 1 - user; end
        2: begin rd = 1; wr = 1 - user; end
        3: begin rd = 1; wr = 1; end
        5: rd = 1 - user;
        6, 7: rd = 1;
        default: ;
      endcase
    end
    ex = ((rd + wr) > 0 && xe == 0) ? 1 : 0;             // R10
    need = (acc == 0) ? rd : (acc == 1) ? wr : ex;       // R11
    if (need == 0) return 5'b000_11;
    return {rd[0], wr[0], ex[0], 2'b00};
  endfunction

  task automatic check(input string tag, input logic [4:0] exp_v, input logic exp_valid);
    logic [4:0] act;
    act = {rsp_rd, rsp_wr, rsp_ex, rsp_fault};
    checks++;
    if (act !== exp_v || rsp_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s: actual valid=%b rd/wr/ex/fault=%b expected valid=%b %b",
               tag, rsp_valid, act, exp_valid, exp_v);
    end
  endtask

  task automatic write_dacr(input logic [31:0] v);
    @(negedge clk);
    dacr_we = 1'b1; dacr_wdata = v;
    @(negedge clk);
    dacr_we = 1'b0;
    shadow = v;
  endtask

  task automatic request(input int dom, input int ap, input int xn, input int pxn,
                         input int acc, input int user, input int afe, input string tag);
    logic [31:0] sh;
    @(negedge clk);
    req_valid = 1'b1; req_domain = 4'(dom); req_ap = 3'(ap);
    req_xn = 1'(xn); req_pxn = 1'(pxn); req_acc = 2'(acc);
    req_user = 1'(user); req_afe = 1'(afe);
    @(negedge clk);
    req_valid = 1'b0;
    sh = shadow >> (2 * dom);
    check(tag, model(int'(sh[1:0]), ap, xn, pxn, acc, user, afe), 1'b1);
  endtask

  function automatic logic [31:0] pattern(input int base, input int rot);
    logic [31:0] v;
    for (int d = 0; d < 16; d++) v[2*d +: 2] = 2'((d * base + rot) % 4);
    return v;
  endfunction

  initial begin
    logic [31:0] v;
    logic [4:0]  held;
    rst_n = 1'b0; dacr_we = 1'b0; dacr_wdata = '0; req_valid = 1'b0;
    req_ap = '0; req_xn = 1'b0; req_pxn = 1'b0; req_domain = '0;
    req_acc = '0; req_user = 1'b0; req_afe = 1'b0; shadow = '0;
    repeat (5) @(negedge clk);
    check("R1 reset state", 5'b000_00, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", 5'b000_00, 1'b0);

    // R2: cleared register faults every domain
    for (int d = 0; d < 16; d++) request(d, 3, 0, 0, 0, 0, 0, "R2 reset domain fault");

    // R3: each domain position decoded from its own bit pair
    for (int p = 0; p < 4; p++) begin
      write_dacr(pattern(p + 1, p));
      for (int d = 0; d < 16; d++) request(d, 3, 0, 0, 0, 0, 0, "R3 domain position");
    end

    // Near-exhaustive sweep on domain 5 for each setting: R4..R12
    for (int dv = 0; dv < 4; dv++) begin
      v = pattern(1, 3 - dv);
      v[11:10] = 2'(dv);
      write_dacr(v);
      for (int ap = 0; ap < 8; ap++)
        for (int xn = 0; xn < 2; xn++)
          for (int pxn = 0; pxn < 2; pxn++)
            for (int acc = 0; acc < 4; acc++)
              for (int user = 0; user < 2; user++)
                for (int afe = 0; afe < 2; afe++)
                  request(5, ap, xn, pxn, acc, user, afe, "R4-sweep R5 R6 R7 R8 R9 R10 R11 R12");
    end

    // R6: execute-never fetch wins over access-flag fault
    v = shadow; v[1:0] = 2'd1; write_dacr(v);
    request(0, 2, 1, 0, 2, 0, 1, "R6 xn fetch before access flag");
    request(0, 2, 0, 1, 3, 0, 1, "R6 pxn fetch before access flag");
    // R5: user ignores pxn
    request(0, 3, 0, 1, 2, 1, 0, "R5 user ignores pxn");

    // R1: fields hold while idle
    request(0, 3, 0, 0, 1, 0, 0, "R1 before hold");
    held = {rsp_rd, rsp_wr, rsp_ex, rsp_fault};
    req_ap = 3'd0; req_acc = 2'd2; req_xn = 1'b1;
    @(negedge clk);
    check("R1 hold while idle", held, 1'b0);

    // R2: same-cycle write uses old contents
    @(negedge clk);
    dacr_we = 1'b1; dacr_wdata = 32'hFFFF_FFFF;
    req_valid = 1'b1; req_domain = 4'd0; req_ap = 3'd0; req_xn = 1'b0;
    req_pxn = 1'b0; req_acc = 2'd0; req_user = 1'b0; req_afe = 1'b0;
    @(negedge clk);
    dacr_we = 1'b0; req_valid = 1'b0;
    check("R2 write same cycle uses old", 5'b000_11, 1'b1);
    shadow = 32'hFFFF_FFFF;
    request(0, 0, 0, 0, 0, 0, 0, "R2 write visible next");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule